// File: doc/BRIEF.md
# Decode-Stage Loop Capture Detector

This block sits beside the instruction decoder. For every decoded control-transfer instruction it decides whether the instruction closes a small innermost loop that the issue queue could hold whole. It reports the outcome one cycle later in one of two ways. It raises a capture pulse together with the loop's first and last instruction addresses, or it raises a reject pulse.

The decision uses static information only. The loop must run backward. Its body, counted in 4-byte instructions from the target up to and including the branch itself, must fit in the issue-queue capacity supplied on an input. A small table remembers address ranges already found uncapturable. A loop is refused when it equals a remembered range or encloses one, because an enclosing loop is then not innermost. External control adds ranges to the table through an insert port when a buffering attempt is abandoned. The table replaces its entries round-robin and ignores duplicate inserts.

Top module: `loop_capture_detector`

## Requirements
- R1: After reset both pulses are low, head and tail read zero, and the table is empty, so a qualifying loop is captured at once.
- R2: Only class codes 2'b01 (conditional branch) and 2'b10 (direct jump) are examined. Codes 2'b00 and 2'b11, and cycles with the strobe low, raise neither pulse.
- R3: A candidate whose target is not strictly below its own address is rejected.
- R4: The body length ((pc - target) >> 2) + 1 must be at most the capacity input. A length equal to the capacity is captured, and one more than the capacity is rejected.
- R5: Each examined instruction gives exactly one of capture or reject, in the cycle after the strobe and for one cycle. On capture, head is the target address and tail is the branch address.
- R6: A candidate is rejected when any valid table entry's range [entry target, entry pc] lies within [target, pc], whether equal or strictly inside. Ranges that only partly overlap do not block.
- R7: An insert takes effect for decodes in the following cycle. A decode in the same cycle as the insert uses the earlier table contents.
- R8: The table holds 4 entries. Inserts fill slots in round-robin order, so the fifth distinct insert evicts the first.
- R9: An insert whose pc and target exactly equal a valid entry changes nothing and does not advance the replacement order.
- R10: Head and tail hold their last captured values while no capture is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | Decoded instruction present this cycle |
| dec_kind_i | input | 2 | Instruction class: 01 conditional branch, 10 direct jump, else other |
| dec_pc_i | input | ADDR_W | Address of the decoded instruction |
| dec_target_i | input | ADDR_W | Static target address |
| iq_capacity_i | input | CAP_W | Issue-queue entries available to a loop |
| blk_ins_i | input | 1 | Insert a range into the uncapturable table |
| blk_ins_pc_i | input | ADDR_W | Branch address of the range to insert |
| blk_ins_target_i | input | ADDR_W | Target address of the range to insert |
| loop_hit_o | output | 1 | Capture pulse |
| loop_reject_o | output | 1 | Reject pulse |
| loop_head_o | output | ADDR_W | First address of the last captured loop |
| loop_tail_o | output | ADDR_W | Branch address of the last captured loop |

## Verification
Random decodes drawn from a 1 KB address window mix all four class codes, forward and backward targets, and capacities around the body lengths. This separates rejection for direction, for length and for table blocking. Random inserts within the same window create many equal, enclosed and partly overlapping ranges, which tells exact-match blocking apart from enclosure blocking. Directed cases pin the length boundary at capacity and capacity plus one, and decode a range in the same cycle it is inserted and again one cycle later. Further directed cases fill the table past four entries to show which slot is evicted, and repeat an insert to show that the replacement order does not move.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER  = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_JUMP   = 2'b10,
    CLS_RSVD   = 2'b11
  } ct_class_e;

  function automatic logic is_ctrl_xfer(input logic [1:0] kind);
    return (kind == CLS_BRANCH) || (kind == CLS_JUMP);
  endfunction
endpackage

// File: rtl/lcd_range_check.sv
module lcd_range_check #(
  parameter int ADDR_W = 32,
  parameter int CAP_W  = 10
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [CAP_W-1:0]  capacity_i,
  output logic              backward_o,
  output logic              fits_o
);
  localparam int PAD_W = ADDR_W - CAP_W;

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] body_len;
  logic [ADDR_W-1:0] cap_ext;

  always_comb begin
    backward_o = (target_i < pc_i);
    span       = pc_i - target_i;
    body_len   = (span >> 2) + ADDR_W'(1);
    cap_ext    = {{PAD_W{1'b0}}, capacity_i};
    fits_o     = backward_o && (body_len <= cap_ext);
  end
endmodule

// File: rtl/lcd_block_table.sv
module lcd_block_table #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc_i,
  input  logic [ADDR_W-1:0] lk_target_i,
  output logic              lk_blocked_o,
  input  logic              ins_i,
  input  logic [ADDR_W-1:0] ins_pc_i,
  input  logic [ADDR_W-1:0] ins_target_i
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] ent_v_q;
  logic [ADDR_W-1:0]  ent_pc_q  [ENTRIES];
  logic [ADDR_W-1:0]  ent_tgt_q [ENTRIES];
  logic [ENTRIES-1:0] enclosed;
  logic [ENTRIES-1:0] dup;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               wr_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_this;
    always_comb begin
      enclosed[g] = ent_v_q[g] && (lk_target_i <= ent_tgt_q[g]) &&
                    (ent_pc_q[g] <= lk_pc_i);
      dup[g]      = ent_v_q[g] && (ent_pc_q[g] == ins_pc_i) &&
                    (ent_tgt_q[g] == ins_target_i);
      wr_this     = wr_en && (ptr_q == PTR_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v_q[g]   <= 1'b0;
        ent_pc_q[g]  <= '0;
        ent_tgt_q[g] <= '0;
      end else if (wr_this) begin
        ent_v_q[g]   <= 1'b1;
        ent_pc_q[g]  <= ins_pc_i;
        ent_tgt_q[g] <= ins_target_i;
      end
    end
  end

  always_comb begin
    lk_blocked_o = |enclosed;
    wr_en        = ins_i && !(|dup);
    ptr_d        = ptr_q;
    if (wr_en) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_d;
  end

  // R8: a fresh insert lands in the slot the pointer named
  p_ins_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_v_q[$past(ptr_q)] &&
              (ent_pc_q[$past(ptr_q)] == $past(ins_pc_i)) &&
              (ent_tgt_q[$past(ptr_q)] == $past(ins_target_i)));

  // R9: a duplicate insert leaves the replacement order alone
  p_dup_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_i && (|dup)) |=> $stable(ptr_q));
endmodule

// File: rtl/loop_capture_detector.sv
module loop_capture_detector #(
  parameter int ADDR_W      = 32,
  parameter int CAP_W       = 10,
  parameter int BLK_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid_i,
  input  logic [1:0]        dec_kind_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  input  logic [ADDR_W-1:0] dec_target_i,
  input  logic [CAP_W-1:0]  iq_capacity_i,
  input  logic              blk_ins_i,
  input  logic [ADDR_W-1:0] blk_ins_pc_i,
  input  logic [ADDR_W-1:0] blk_ins_target_i,
  output logic              loop_hit_o,
  output logic              loop_reject_o,
  output logic [ADDR_W-1:0] loop_head_o,
  output logic [ADDR_W-1:0] loop_tail_o
);
  import lcd_pkg::*;

  logic backward, fits, blocked, examine;
  logic hit_d, rej_d, hit_q, rej_q;
  logic [ADDR_W-1:0] head_q, tail_q;

  lcd_range_check #(.ADDR_W(ADDR_W), .CAP_W(CAP_W)) u_range (
    .pc_i       (dec_pc_i),
    .target_i   (dec_target_i),
    .capacity_i (iq_capacity_i),
    .backward_o (backward),
    .fits_o     (fits)
  );

  lcd_block_table #(.ADDR_W(ADDR_W), .ENTRIES(BLK_ENTRIES)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pc_i      (dec_pc_i),
    .lk_target_i  (dec_target_i),
    .lk_blocked_o (blocked),
    .ins_i        (blk_ins_i),
    .ins_pc_i     (blk_ins_pc_i),
    .ins_target_i (blk_ins_target_i)
  );

  always_comb begin
    examine = dec_valid_i && is_ctrl_xfer(dec_kind_i);
    hit_d   = examine && backward && fits && !blocked;
    rej_d   = examine && !hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      rej_q <= rej_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (hit_d) begin
      head_q <= dec_target_i;
      tail_q <= dec_pc_i;
    end
  end

  assign loop_hit_o    = hit_q;
  assign loop_reject_o = rej_q;
  assign loop_head_o   = head_q;
  assign loop_tail_o   = tail_q;

  // R5: never both outcomes at once
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(loop_hit_o && loop_reject_o));

  // R2: an outcome only follows a strobed branch or jump
  p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_hit_o || loop_reject_o) |->
      $past(dec_valid_i && (dec_kind_i inside {2'b01, 2'b10})));

  // R3: a captured loop always runs backward
  p_backward_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_hit_o |-> (loop_head_o < loop_tail_o));

  // R10: head and tail move only with a capture
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_hit_o |-> ($stable(loop_head_o) && $stable(loop_tail_o)));
endmodule

// File: tb/loop_capture_detector_tb_top.sv
module loop_capture_detector_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int CW = 10;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid;
  logic [1:0] dec_kind;
  logic [AW-1:0] dec_pc, dec_target, ins_pc, ins_tgt;
  logic [CW-1:0] cap;
  logic ins;
  logic hit, rej;
  logic [AW-1:0] head, tail;

  int nchk = 0;
  int nfail = 0;

  logic [AW-1:0] m_pc [NE];
  logic [AW-1:0] m_tg [NE];
  logic          m_v  [NE];
  int            m_ptr;
  logic [AW-1:0] e_head, e_tail;

  always #(CLK_P/2) clk = ~clk;

  loop_capture_detector #(.ADDR_W(AW), .CAP_W(CW), .BLK_ENTRIES(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid), .dec_kind_i(dec_kind),
    .dec_pc_i(dec_pc), .dec_target_i(dec_target), .iq_capacity_i(cap),
    .blk_ins_i(ins), .blk_ins_pc_i(ins_pc), .blk_ins_target_i(ins_tgt),
    .loop_hit_o(hit), .loop_reject_o(rej), .loop_head_o(head), .loop_tail_o(tail)
  );

  function automatic logic model_blocked(input logic [AW-1:0] pc, input logic [AW-1:0] tg);
    logic b = 1'b0;
    for (int i = 0; i < NE; i++)
      if (m_v[i] && tg <= m_tg[i] && m_pc[i] <= pc) b = 1'b1;
    return b;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 1'b0; m_pc[i] = '0; m_tg[i] = '0;
    end
    m_ptr = 0; e_head = '0; e_tail = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dec_valid = 1'b0; dec_kind = 2'b00; dec_pc = '0;
    dec_target = '0; cap = '0; ins = 1'b0; ins_pc = '0; ins_tgt = '0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one cycle at a falling edge, then check at the next falling edge.
  task automatic step(input logic v, input logic [1:0] k, input logic [AW-1:0] pc,
                      input logic [AW-1:0] tg, input logic [CW-1:0] c,
                      input logic in, input logic [AW-1:0] ipc,
                      input logic [AW-1:0] itg, input string tag_in);
    logic eh, er, ex, back, blk, fit;
    logic [AW-1:0] len;
    logic dupl;
    string tag;
    dec_valid = v; dec_kind = k; dec_pc = pc; dec_target = tg; cap = c;
    ins = in; ins_pc = ipc; ins_tgt = itg;
    ex   = v && (k == 2'b01 || k == 2'b10);
    back = tg < pc;
    len  = ((pc - tg) >> 2) + 1;
    fit  = back && (len <= {{(AW-CW){1'b0}}, c});
    blk  = model_blocked(pc, tg);
    eh   = ex && back && fit && !blk;
    er   = ex && !eh;
    if (eh) begin e_head = tg; e_tail = pc; end
    if (!ex) tag = "R2";
    else if (!back) tag = "R3";
    else if (blk) tag = "R6";
    else if (!fit) tag = "R4";
    else tag = "R5";
    if (tag_in != "") tag = tag_in;
    if (in) begin
      dupl = 1'b0;
      for (int i = 0; i < NE; i++)
        if (m_v[i] && m_pc[i] == ipc && m_tg[i] == itg) dupl = 1'b1;
      if (!dupl) begin
        m_v[m_ptr] = 1'b1; m_pc[m_ptr] = ipc; m_tg[m_ptr] = itg;
        m_ptr = (m_ptr + 1) % NE;
      end
    end
    @(negedge clk);
    dec_valid = 1'b0; ins = 1'b0;
    nchk++;
    if (hit !== eh || rej !== er || head !== e_head || tail !== e_tail) begin
      nfail++;
      $display("FAIL %s: hit/rej/head/tail got %b %b %h %h exp %b %b %h %h",
               tag, hit, rej, head, tail, eh, er, e_head, e_tail);
    end
  endtask

  task automatic dec(input logic [1:0] k, input logic [AW-1:0] pc,
                     input logic [AW-1:0] tg, input logic [CW-1:0] c, input string t);
    step(1'b1, k, pc, tg, c, 1'b0, '0, '0, t);
  endtask

  task automatic put(input logic [AW-1:0] pc, input logic [AW-1:0] tg, input string t);
    step(1'b0, 2'b00, '0, '0, '0, 1'b1, pc, tg, t);
  endtask

  initial begin
    #(CLK_P * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not complete, got timeout exp finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1: reset state at the ports
    nchk++;
    if (hit !== 1'b0 || rej !== 1'b0 || head !== '0 || tail !== '0) begin
      nfail++;
      $display("FAIL R1: got %b %b %h %h exp 0 0 0 0", hit, rej, head, tail);
    end
    dec(2'b01, 32'h1010, 32'h1000, 10'd8, "R1");   // empty table, captured
    // R4: boundary, length 65
    dec(2'b01, 32'h1000, 32'h0F00, 10'd65, "R4");
    dec(2'b10, 32'h1000, 32'h0F00, 10'd64, "R4");
    // R3: forward and self targets
    dec(2'b01, 32'h1000, 32'h1040, 10'd64, "R3");
    dec(2'b01, 32'h1000, 32'h1000, 10'd64, "R3");
    // R2: other classes and idle strobe
    dec(2'b00, 32'h1010, 32'h1000, 10'd64, "R2");
    dec(2'b11, 32'h1010, 32'h1000, 10'd64, "R2");
    step(1'b0, 2'b01, 32'h1010, 32'h1000, 10'd64, 1'b0, '0, '0, "R2");
    // R10: reject keeps head and tail
    dec(2'b01, 32'h3000, 32'h2000, 10'd4, "R10");
    // R7: same-cycle decode sees old table, next sees new
    step(1'b1, 2'b01, 32'h1100, 32'h1080, 10'd64, 1'b1, 32'h1100, 32'h1080, "R7");
    dec(2'b01, 32'h1100, 32'h1080, 10'd64, "R7");
    // R6: enclosing, strictly inside, partial overlap
    dec(2'b01, 32'h1200, 32'h1000, 10'd200, "R6");
    dec(2'b01, 32'h1100, 32'h1000, 10'd200, "R6");
    dec(2'b01, 32'h1150, 32'h1090, 10'd200, "R6");
    dec(2'b01, 32'h10F0, 32'h1080, 10'd200, "R6");
    // R8: four more distinct inserts evict the first
    put(32'h1300, 32'h12F0, "R8");
    put(32'h1400, 32'h13F0, "R8");
    put(32'h1500, 32'h14F0, "R8");
    dec(2'b01, 32'h1100, 32'h1080, 10'd64, "R8");
    put(32'h1600, 32'h15F0, "R8");
    dec(2'b01, 32'h1100, 32'h1080, 10'd64, "R8");
    dec(2'b01, 32'h1300, 32'h12F0, 10'd64, "R8");
    // R9: duplicate does not advance replacement
    do_reset();
    put(32'h2100, 32'h2080, "R9");
    put(32'h2100, 32'h2080, "R9");
    put(32'h2200, 32'h2180, "R9");
    put(32'h2300, 32'h2280, "R9");
    put(32'h2400, 32'h2380, "R9");
    dec(2'b01, 32'h2100, 32'h2080, 10'd64, "R9");
    put(32'h2500, 32'h2480, "R9");
    dec(2'b01, 32'h2100, 32'h2080, 10'd64, "R9");
    dec(2'b01, 32'h2200, 32'h2180, 10'd64, "R9");
    // Random mix
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] p, t, ip, it;
      logic [AW-1:0] a, b;
      p  = 32'h2000 + 4 * ($urandom % 256);
      t  = 32'h2000 + 4 * ($urandom % 256);
      a  = 32'h2000 + 4 * ($urandom % 256);
      b  = 32'h2000 + 4 * ($urandom % 256);
      ip = (a > b) ? a : b;
      it = (a > b) ? b : a;
      step(($urandom % 8) != 0, 2'($urandom % 4), p, t, CW'(1 + $urandom % 300),
           ($urandom % 6) == 0, ip, it, "");
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule